// File: doc/BRIEF.md
# Energy-to-Pulse Frequency Converter

This block takes a stream of signed active-power samples, each marked by a valid strobe, and turns the accumulated energy into pulses. A fast calibration pulse output fires every time a fixed quantum of energy has been collected. Its rate follows the instantaneous load and is suited to meter calibration under a steady load. Two slow outputs pulse in turn, once for each fixed group of calibration pulses. Their rate follows the average power, and because they alternate they can drive a two-phase stepper counter directly. Both pulse trains come from one energy register, so they stay locked to each other.

Two select bits set the energy quantum behind one slow pulse. A third bit sets how many calibration pulses make up one slow pulse, which moves the calibration rate without changing the slow rate. Samples whose magnitude is below a no-load level are discarded, so an idle meter never counts. A reverse-power flag reports the sign of the energy that produced the most recent calibration pulse. Holding the asynchronous reset low, or dropping the supply-good input, clears all accumulated energy, the flag and any pulse in progress.

Top module: `energy_pulse_conv`

## Requirements
- R1: While `rst_n` is low or `supply_ok` is low, `cf`, `f1` and `f2` are low and `rev_power` is 0. Energy accumulated before such a clear never produces a pulse afterwards.
- R2: A valid sample with magnitude below CREEP_MIN (default 4) is discarded. A sample whose magnitude equals CREEP_MIN is accumulated.
- R3: The magnitude of each accepted sample is added to an energy register. A calibration event occurs when that register is at least the calibration level T_cf, and T_cf is then subtracted so the residue is kept. For a burst of energy E, exactly floor(E / T_cf) calibration pulses appear.
- R4: The slow-output level is T_f = BASE_THR · 2^fsel (256, 512, 1024, 2048 by default). T_cf = T_f / 2^s, where s = CF_SHIFT_LO (2) when `cf_fast` = 0 and s = CF_SHIFT_HI (3) when `cf_fast` = 1.
- R5: Each group of 2^s calibration events produces one slow event. Its pulse starts in the same cycle as the calibration pulse that completes the group.
- R6: Slow pulses alternate between `f1` and `f2`, beginning with `f1` after a clear. `f1` and `f2` are never high together.
- R7: Every pulse on `cf`, `f1` or `f2` rises the cycle after its event and stays high for exactly PULSE_W cycles (default 2). Calibration events are spaced at least 2·PULSE_W cycles apart. Energy that exceeds this rate is held back and emitted later.
- R8: `rev_power` changes only at a calibration event. It then takes the sign of the latest accepted sample (1 = negative).
- R9: For a given energy E, the slow pulse count is floor(E / T_f) whatever the value of `cf_fast`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok | input | 1 | Supply good; low clears the block and silences the outputs |
| smp_valid | input | 1 | Power sample strobe |
| smp_power | input | SAMPLE_W | Signed active-power sample |
| fsel | input | 2 | Base energy-level select |
| cf_fast | input | 1 | Selects the larger calibration-to-slow ratio |
| f1 | output | 1 | Slow pulse, phase A |
| f2 | output | 1 | Slow pulse, phase B |
| cf | output | 1 | Calibration pulse |
| rev_power | output | 1 | 1 when the last pulsed energy was negative |

## Verification
A wrong energy residue shows up as a calibration pulse count that is off by one or more for a known burst. It becomes visible as soon as the backlog drains, within 2·PULSE_W cycles per pending event. A faulty group counter or phase register shows at the first slow pulse: the count is wrong, the pulse comes out on the wrong output, or it rises out of step with `cf`. Residue or a flag that survives a clear shows as pulses, or a set flag, after `supply_ok` returns, even though no new samples were given. A broken creep gate shows as pulses during a long run of sub-threshold samples.

// File: rtl/epc_pkg.sv
package epc_pkg;

  // Energy level behind one slow-output pulse.
  function automatic int unsigned f_level(input int unsigned base, input logic [1:0] fsel);
    return base << fsel;
  endfunction

  // log2 of the calibration-to-slow pulse ratio.
  function automatic int unsigned cf_shift(input logic fast, input int unsigned lo,
                                           input int unsigned hi);
    return fast ? hi : lo;
  endfunction

  // Energy level behind one calibration pulse.
  function automatic int unsigned cf_level(input int unsigned base, input logic [1:0] fsel,
                                           input logic fast, input int unsigned lo,
                                           input int unsigned hi);
    return f_level(base, fsel) >> cf_shift(fast, lo, hi);
  endfunction

  // Calibration pulses per slow pulse.
  function automatic int unsigned group_size(input logic fast, input int unsigned lo,
                                             input int unsigned hi);
    return 32'd1 << cf_shift(fast, lo, hi);
  endfunction

endpackage

// File: rtl/epc_energy_acc.sv
module epc_energy_acc #(
  parameter int SAMPLE_W  = 16,
  parameter int ACC_W     = 24,
  parameter int CREEP_MIN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_power,
  input  logic [ACC_W-1:0]           level,
  input  logic                       ready,
  output logic                       evt,
  output logic                       last_neg
);
  localparam int MAG_W = SAMPLE_W + 1;
  localparam logic [ACC_W:0] ACC_MAX = {1'b0, {ACC_W{1'b1}}};

  function automatic logic [MAG_W-1:0] magnitude(input logic signed [SAMPLE_W-1:0] p);
    logic signed [MAG_W-1:0] w;
    w = {p[SAMPLE_W-1], p};
    return p[SAMPLE_W-1] ? MAG_W'(-w) : MAG_W'(w);
  endfunction

  logic [ACC_W-1:0] acc;
  logic [MAG_W-1:0] mag;
  logic             accept;
  logic [ACC_W:0]   sum_w;
  logic [ACC_W-1:0] acc_next;

  assign mag    = magnitude(smp_power);
  assign accept = smp_valid && (mag >= MAG_W'(CREEP_MIN));
  assign evt    = ready && !clear && (acc >= level);

  always_comb begin
    sum_w = {1'b0, acc};
    if (evt)    sum_w = sum_w - {1'b0, level};
    if (accept) sum_w = sum_w + (ACC_W+1)'(mag);
    acc_next = (sum_w > ACC_MAX) ? ACC_MAX[ACC_W-1:0] : sum_w[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      last_neg <= 1'b0;
    end else if (clear) begin
      acc      <= '0;
      last_neg <= 1'b0;
    end else begin
      acc <= acc_next;
      if (accept) last_neg <= smp_power[SAMPLE_W-1];
    end
  end

  // R2
  creep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !accept && !evt && !clear) |=> (acc == $past(acc)));

  // R1
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc == '0 && !last_neg));

endmodule

// File: rtl/epc_pulse_timer.sv
module epc_pulse_timer #(
  parameter int PULSE_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic fire,
  output logic pulse,
  output logic busy
);
  localparam int SPAN  = 2 * PULSE_W;
  localparam int CNT_W = $clog2(SPAN + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clear)       cnt <= '0;
    else if (fire)        cnt <= CNT_W'(SPAN);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign pulse = cnt > CNT_W'(PULSE_W);
  assign busy  = cnt != '0;

  // R7
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !clear) |=> pulse);

  // R7
  spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !busy);

  // R1
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !busy);

endmodule

// File: rtl/epc_phase_divider.sv
module epc_phase_divider #(
  parameter int GRP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [GRP_W-1:0] group,
  output logic             fire,
  output logic             phase_sel
);
  logic [GRP_W-1:0] cnt;
  logic             next_phase;
  logic             wrap;

  assign wrap = ({1'b0, cnt} + 1'b1) >= {1'b0, group};
  assign fire = tick && wrap && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      next_phase <= 1'b0;
      phase_sel  <= 1'b0;
    end else if (clear) begin
      cnt        <= '0;
      next_phase <= 1'b0;
      phase_sel  <= 1'b0;
    end else if (tick) begin
      if (wrap) begin
        cnt        <= '0;
        phase_sel  <= next_phase;
        next_phase <= ~next_phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5
  group_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && $stable(group)) |=> (cnt < group));

endmodule

// File: rtl/energy_pulse_conv.sv
module energy_pulse_conv #(
  parameter int SAMPLE_W    = 16,
  parameter int ACC_W       = 24,
  parameter int BASE_THR    = 256,
  parameter int CF_SHIFT_LO = 2,
  parameter int CF_SHIFT_HI = 3,
  parameter int CREEP_MIN   = 4,
  parameter int PULSE_W     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       supply_ok,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_power,
  input  logic [1:0]                 fsel,
  input  logic                       cf_fast,
  output logic                       f1,
  output logic                       f2,
  output logic                       cf,
  output logic                       rev_power
);
  import epc_pkg::*;

  localparam int GRP_W = CF_SHIFT_HI + 2;

  logic             clear;
  logic [ACC_W-1:0] cf_lvl;
  logic [GRP_W-1:0] grp;
  logic             cf_evt, cf_pulse, cf_busy;
  logic             f_evt, f_sel, f_pulse, f_busy;
  logic             last_neg;

  assign clear  = !supply_ok;
  assign cf_lvl = ACC_W'(cf_level(BASE_THR, fsel, cf_fast, CF_SHIFT_LO, CF_SHIFT_HI));
  assign grp    = GRP_W'(group_size(cf_fast, CF_SHIFT_LO, CF_SHIFT_HI));

  epc_energy_acc #(
    .SAMPLE_W (SAMPLE_W),
    .ACC_W    (ACC_W),
    .CREEP_MIN(CREEP_MIN)
  ) i_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .smp_valid(smp_valid),
    .smp_power(smp_power),
    .level    (cf_lvl),
    .ready    (!cf_busy),
    .evt      (cf_evt),
    .last_neg (last_neg)
  );

  epc_pulse_timer #(.PULSE_W(PULSE_W)) i_cf_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(clear),
    .fire (cf_evt),
    .pulse(cf_pulse),
    .busy (cf_busy)
  );

  epc_phase_divider #(.GRP_W(GRP_W)) i_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .tick     (cf_evt),
    .group    (grp),
    .fire     (f_evt),
    .phase_sel(f_sel)
  );

  epc_pulse_timer #(.PULSE_W(PULSE_W)) i_f_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(clear),
    .fire (f_evt),
    .pulse(f_pulse),
    .busy (f_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rev_power <= 1'b0;
    else if (clear)  rev_power <= 1'b0;
    else if (cf_evt) rev_power <= last_neg;
  end

  assign cf = cf_pulse & supply_ok;
  assign f1 = f_pulse & ~f_sel & supply_ok;
  assign f2 = f_pulse & f_sel & supply_ok;

  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(f1 && f2));

  // R5
  f_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_pulse) |-> $rose(cf_pulse));

  // R8
  rev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cf_evt && !clear) |=> $stable(rev_power));

  // R7
  f_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_evt |-> !f_busy);

endmodule

// File: tb/test_energy_pulse_conv.sv
`timescale 1ns/1ps
module test_energy_pulse_conv;
  localparam int BASE = 256;
  localparam int SH_LO = 2;
  localparam int SH_HI = 3;
  localparam int CMIN = 4;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [15:0] smp_power = '0;
  logic [1:0] fsel = '0;
  logic cf_fast = 1'b0;
  logic f1, f2, cf, rev_power;

  always #2.5 clk = ~clk;

  energy_pulse_conv i_energy_pulse_conv (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .smp_valid(smp_valid),
    .smp_power(smp_power), .fsel(fsel), .cf_fast(cf_fast),
    .f1(f1), .f2(f2), .cf(cf), .rev_power(rev_power)
  );

  int total = 0;
  int fails = 0;
  bit done = 0;

  // Port monitor, sampled on the falling edge.
  int n_cf = 0, n_f1 = 0, n_f2 = 0, n_unsync = 0, n_overlap = 0, n_badw = 0;
  int run_cf = 0, run_f1 = 0, run_f2 = 0;
  logic p_cf = 0, p_f1 = 0, p_f2 = 0;

  always @(negedge clk) begin
    if (cf && !p_cf) n_cf++;
    if (f1 && !p_f1) n_f1++;
    if (f2 && !p_f2) n_f2++;
    if (((f1 && !p_f1) || (f2 && !p_f2)) && !(cf && !p_cf)) n_unsync++;
    if (f1 && f2) n_overlap++;
    if (cf) run_cf++; else begin if (p_cf && run_cf != PW) n_badw++; run_cf = 0; end
    if (f1) run_f1++; else begin if (p_f1 && run_f1 != PW) n_badw++; run_f1 = 0; end
    if (f2) run_f2++; else begin if (p_f2 && run_f2 != PW) n_badw++; run_f2 = 0; end
    p_cf = cf; p_f1 = f1; p_f2 = f2;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic do_clear();
    cycles(1);
    supply_ok = 1'b0;
    cycles(4);
    supply_ok = 1'b1;
    cycles(1);
  endtask

  task automatic feed(input int p, input int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk); #1;
      smp_valid = 1'b1;
      smp_power = 16'(p);
    end
    @(posedge clk); #1;
    smp_valid = 1'b0;
    smp_power = '0;
  endtask

  task automatic sweep(input int fs, input int fa, input int p, input int k);
    int tf, s, tcf, e, ecf, ef;
    int c0, a0, b0, u0, o0, w0;
    tf  = BASE << fs;
    s   = fa ? SH_HI : SH_LO;
    tcf = tf >> s;
    e   = k * (p < 0 ? -p : p);
    ecf = e / tcf;
    ef  = ecf >> s;
    fsel = 2'(fs);
    cf_fast = fa[0];
    do_clear();
    c0 = n_cf; a0 = n_f1; b0 = n_f2; u0 = n_unsync; o0 = n_overlap; w0 = n_badw;
    feed(p, k);
    cycles(2500);
    check(n_cf - c0 == ecf, "R3 cf pulse count", n_cf - c0, ecf);
    check((n_f1 - a0) + (n_f2 - b0) == e / tf, "R4 R9 slow pulse count",
          (n_f1 - a0) + (n_f2 - b0), e / tf);
    check(n_f1 - a0 == (ef + 1) / 2, "R6 f1 share", n_f1 - a0, (ef + 1) / 2);
    check(n_f2 - b0 == ef / 2, "R6 f2 share", n_f2 - b0, ef / 2);
    check(n_unsync == u0, "R5 slow pulse out of step with cf", n_unsync - u0, 0);
    check(n_overlap == o0, "R6 overlap cycles", n_overlap - o0, 0);
    check(n_badw == w0, "R7 pulse width errors", n_badw - w0, 0);
    check(rev_power == (p < 0), "R8 rev flag", int'(rev_power), int'(p < 0));
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int c0, a0, b0, busy_cnt;
    cycles(3);
    check(!cf && !f1 && !f2, "R1 outputs in reset", int'({cf, f1, f2}), 0);
    check(rev_power == 1'b0, "R1 rev in reset", int'(rev_power), 0);
    rst_n = 1'b1;
    cycles(2);

    // R3 R4 R5 R6 R7 R8 R9: full sweep of fsel x cf_fast.
    for (int fs = 0; fs < 4; fs++)
      for (int fa = 0; fa < 2; fa++)
        sweep(fs, fa, ((fs + fa) % 2 == 1) ? -(37 + 20 * fs) : (37 + 20 * fs), 150);

    // R2: samples below the creep level produce nothing.
    fsel = 2'd0; cf_fast = 1'b1;
    do_clear();
    c0 = n_cf; a0 = n_f1; b0 = n_f2;
    feed(3, 300);
    feed(-3, 300);
    cycles(200);
    check(n_cf == c0, "R2 cf under creep level", n_cf - c0, 0);
    check(n_f1 + n_f2 == a0 + b0, "R2 slow under creep level", n_f1 + n_f2 - a0 - b0, 0);
    check(rev_power == 1'b0, "R2 rev under creep level", int'(rev_power), 0);

    // R2: magnitude exactly at the creep level counts (T_cf = 64).
    cf_fast = 1'b0;
    do_clear();
    c0 = n_cf; a0 = n_f1;
    feed(-CMIN, 64);
    cycles(300);
    check(n_cf - c0 == 4, "R2 cf at creep level", n_cf - c0, 4);
    check(n_f1 - a0 == 1, "R2 f1 at creep level", n_f1 - a0, 1);
    check(rev_power == 1'b1, "R8 rev negative", int'(rev_power), 1);

    // R1: supply drop clears residue, flag and pulses.
    fsel = 2'd0; cf_fast = 1'b1;
    do_clear();
    feed(-200, 20);
    cycles(50);
    check(rev_power == 1'b1, "R8 rev before drop", int'(rev_power), 1);
    supply_ok = 1'b0;
    busy_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cf || f1 || f2) busy_cnt++;
    end
    check(busy_cnt == 0, "R1 quiet while supply low", busy_cnt, 0);
    check(rev_power == 1'b0, "R1 rev cleared", int'(rev_power), 0);
    @(posedge clk); #1;
    supply_ok = 1'b1;
    c0 = n_cf; a0 = n_f1; b0 = n_f2;
    cycles(1000);
    check(n_cf == c0, "R1 no residue pulses", n_cf - c0, 0);
    check(n_f1 + n_f2 == a0 + b0, "R1 no residue slow pulses", n_f1 + n_f2 - a0 - b0, 0);
    check(rev_power == 1'b0, "R1 rev stays clear", int'(rev_power), 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule